// File: doc/BRIEF.md
# Flash Controller Status and Interrupt Register Unit

This unit holds the control word and the event status word of a flash memory controller behind a single-cycle register port. The command engine and the data path signal events as one-cycle pulses on `evt_set`. Each pulse sets a sticky status bit that stays set until software writes a 1 to it. The low twelve control bits act as per-event interrupt disables. A single interrupt line is raised while any enabled status bit from 11 down to 0 is set.

The control word also carries the run flag and the static configuration fields: spare area enable, ECC enable, DMA enable, the two bus widths, page size, ID byte count, addressing order, pages per block and arbitration. The command engine reads these through `ctrl_o`. Software starts a command by clearing the control word, clearing the status bits, and then writing the control word with run set. A write-command request event is accepted only while run is set. Run clears itself when the command-done event for the selected chip select is latched.

Status bit map, bit 12 down to bit 0: controller ready (12), flash ready (11), page done for chip select 0 (10) and 1 (9), command done for chip select 0 (8) and 1 (7), bad block for chip select 0 (6) and 1 (5), uncorrectable ECC (4), corrected ECC (3), write data request (2), read data request (1), write command request (0).

Top module: `nfc_status_unit`

## Requirements
- R1: After reset the control word reads 0x00000FFF, which masks every interrupt. The status word reads 0, `irq_o` is 0 and `run_o` is 0.
- R2: A one-cycle pulse on `evt_set[k]` sets status bit k at the next clock edge. The bit stays set after the pulse ends.
- R3: A write with `reg_sel`=1 clears each status bit whose data bit is 1 and leaves the other bits unchanged. A write of 0x1FFF clears all thirteen bits.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is 1 exactly when some bit k in 11..0 has status 1 and control bit k equal to 0. Status bit 12 never raises `irq_o`.
- R6: A write with `reg_sel`=0 stores only the implemented control bits, which form the mask 0xFD07DFFF. All other control bits read as 0.
- R7: A pulse on `evt_set[0]` (write command request) is ignored while run (control bit 28) is 0, and it latches while run is 1.
- R8: Run clears at the clock edge at which a command-done pulse for the active chip select is latched. That pulse is bit 8 when `active_cs`=0 and bit 7 when `active_cs`=1. A done pulse for the other chip select leaves run set.
- R9: When a control write and a run-clearing done pulse occur in the same cycle, the written value is stored.
- R10: A pulse on `clk_restart` sets status bits 12 and 11, so a cleared status word reads 0x1800.
- R11: `ctrl_o` always equals the control word, and `run_o` equals control bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word, available in the same cycle |
| evt_set | input | 13 | One-cycle event pulses, one per status bit |
| clk_restart | input | 1 | Pulse marking a controller clock restart |
| active_cs | input | 1 | Chip select of the command in flight |
| ctrl_o | output | 32 | Control word for the command engine |
| run_o | output | 1 | Run flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The collisions are the hardest cases to reach from the ports. One is a set pulse meeting a clear write on the same bit. The other is a done pulse meeting a control write in the same cycle. Both need several inputs driven on one edge, so the vector table carries a write, an event vector and a chip select in the same row. The chip-select dependence of the run self-clear is checked by first sending the done pulse of the other select and confirming that run holds.

// File: rtl/nfc_stat_pkg.sv
package nfc_stat_pkg;
   localparam int unsigned CTRL_W   = 32;
   localparam int unsigned STAT_W   = 13;
   localparam int unsigned MASK_W   = 12;
   localparam int unsigned RUN_POS  = 28;
   localparam int unsigned CTL_RDY  = 12;
   localparam int unsigned FL_RDY   = 11;
   localparam int unsigned CS0_DONE = 8;
   localparam int unsigned CS1_DONE = 7;
   localparam int unsigned WCMD_REQ = 0;
   // implemented control bits: configuration fields, run and masks
   localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'hFD07_DFFF;
   localparam logic [CTRL_W-1:0] CTRL_RST   = 32'h0000_0FFF;
endpackage

// File: rtl/nfc_ctrl_reg.sv
module nfc_ctrl_reg #(
   parameter int unsigned W       = 32,
   parameter int unsigned RUN_BIT = 28,
   parameter logic [W-1:0] WMASK  = '1,
   parameter logic [W-1:0] RSTVAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic         hw_clr_run,
   output logic [W-1:0] q
);
   if (RUN_BIT >= W) begin : g_bad_run
      $error("run bit position outside the control word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RSTVAL & WMASK;
      else if (wr_en)
         q <= wdata & WMASK;
      else if (hw_clr_run)
         q[RUN_BIT] <= 1'b0;
   end
endmodule

// File: rtl/nfc_stat_bank.sv
module nfc_stat_bank #(
   parameter int unsigned N = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("status bank needs at least one bit");
   end

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cell_q <= 1'b0;
         else
            cell_q <= set_vec[i] | (cell_q & ~clr_vec[i]);
      end
      assign q[i] = cell_q;
   end
endmodule

// File: rtl/nfc_irq_merge.sv
module nfc_irq_merge #(
   parameter int unsigned W = 12
) (
   input  logic [W-1:0] stat,
   input  logic [W-1:0] dis_mask,
   output logic         irq
);
   logic [W-1:0] live;

   for (genvar i = 0; i < W; i++) begin : g_gate
      assign live[i] = stat[i] & ~dis_mask[i];
   end

   assign irq = |live;
endmodule

// File: rtl/nfc_status_unit.sv
module nfc_status_unit
   import nfc_stat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic [STAT_W-1:0] evt_set,
   input  logic              clk_restart,
   input  logic              active_cs,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              run_o,
   output logic              irq_o
);
   localparam int unsigned PAD_W = CTRL_W - STAT_W;

   if (MASK_W >= STAT_W || STAT_W > CTRL_W) begin : g_bad_widths
      $error("mask and status widths do not fit the control word");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic              ctrl_wr;
   logic              stat_wr;
   logic              run;
   logic              done_hit;

   assign ctrl_wr  = reg_wr & ~reg_sel;
   assign stat_wr  = reg_wr & reg_sel;
   assign run      = ctrl_q[RUN_POS];
   assign done_hit = active_cs ? evt_set[CS1_DONE] : evt_set[CS0_DONE];

   always_comb begin
      set_vec           = evt_set;
      set_vec[WCMD_REQ] = evt_set[WCMD_REQ] & run;
      set_vec[CTL_RDY]  = evt_set[CTL_RDY] | clk_restart;
      set_vec[FL_RDY]   = evt_set[FL_RDY] | clk_restart;
      clr_vec           = stat_wr ? reg_wdata[STAT_W-1:0] : '0;
   end

   nfc_ctrl_reg #(
      .W      (CTRL_W),
      .RUN_BIT(RUN_POS),
      .WMASK  (CTRL_WMASK),
      .RSTVAL (CTRL_RST)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr),
      .wdata     (reg_wdata),
      .hw_clr_run(done_hit & run),
      .q         (ctrl_q)
   );

   nfc_stat_bank #(.N(STAT_W)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .q      (stat_q)
   );

   nfc_irq_merge #(.W(MASK_W)) u_irq (
      .stat    (stat_q[MASK_W-1:0]),
      .dis_mask(ctrl_q[MASK_W-1:0]),
      .irq     (irq_o)
   );

   assign reg_rdata = reg_sel ? {{PAD_W{1'b0}}, stat_q} : ctrl_q;
   assign ctrl_o    = ctrl_q;
   assign run_o     = run;
endmodule

// File: rtl/nfc_status_unit_chk.sv
module nfc_status_unit_chk
   import nfc_stat_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_sel,
   input logic [STAT_W-1:0] wdata_lo,
   input logic [STAT_W-1:0] evt_set,
   input logic              clk_restart,
   input logic              active_cs,
   input logic              irq_o,
   input logic              run_q,
   input logic [STAT_W-1:0] stat_q
);
   for (genvar k = 1; k < STAT_W; k++) begin : g_set
      // R4: a pulse always lands, even against a clear write
      a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         evt_set[k] |=> stat_q[k]);
   end

   for (genvar k = 0; k < STAT_W; k++) begin : g_clr
      a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_sel && wdata_lo[k] && !evt_set[k] && !clk_restart)
         |=> !stat_q[k]);
   end

   a_r7_wcmd_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !stat_q[WCMD_REQ]) |=> !stat_q[WCMD_REQ]);

   a_r8_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !(reg_wr && !reg_sel) &&
       (active_cs ? evt_set[CS1_DONE] : evt_set[CS0_DONE])) |=> !run_q);

   a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clk_restart |=> (stat_q[CTL_RDY] && stat_q[FL_RDY]));

   a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q == '0) |-> !irq_o);
endmodule

bind nfc_status_unit nfc_status_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_sel    (reg_sel),
   .wdata_lo   (reg_wdata[12:0]),
   .evt_set    (evt_set),
   .clk_restart(clk_restart),
   .active_cs  (active_cs),
   .irq_o      (irq_o),
   .run_q      (ctrl_q[28]),
   .stat_q     (stat_q)
);

// File: tb/tb_nfc_status_unit.sv
module tb_nfc_status_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 16;

   typedef struct packed {
      logic        wr;
      logic        sel;
      logic [31:0] wd;
      logic [12:0] ev;
      logic        rs;
      logic        cs;
      logic        csel;
      logic [31:0] exp;
      logic        irq;
      logic [3:0]  req;
   } vec_t;

   // wr sel wdata ev rs cs csel expected irq req
   localparam vec_t VEC [NVEC] = '{
      '{1'b1,1'b0,32'h0000_0000,13'h0000,1'b0,1'b0,1'b0,32'h0000_0000,1'b0,4'd6},  // R6 unmask all
      '{1'b0,1'b0,32'h0,13'h0001,1'b0,1'b0,1'b1,32'h0000_0000,1'b0,4'd7},          // R7 ignored
      '{1'b1,1'b0,32'h1000_0000,13'h0000,1'b0,1'b0,1'b0,32'h1000_0000,1'b0,4'd11}, // R11 run
      '{1'b0,1'b0,32'h0,13'h0001,1'b0,1'b0,1'b1,32'h0000_0001,1'b1,4'd7},          // R7 latched
      '{1'b0,1'b0,32'h0,13'h0008,1'b0,1'b0,1'b1,32'h0000_0009,1'b1,4'd2},          // R2 sticky
      '{1'b1,1'b1,32'h0000_0001,13'h0000,1'b0,1'b0,1'b1,32'h0000_0008,1'b1,4'd3},  // R3 partial
      '{1'b1,1'b0,32'h1000_0008,13'h0000,1'b0,1'b0,1'b1,32'h0000_0008,1'b0,4'd5},  // R5 mask
      '{1'b0,1'b0,32'h0,13'h1000,1'b0,1'b0,1'b1,32'h0000_1008,1'b0,4'd5},          // R5 bit 12
      '{1'b0,1'b0,32'h0,13'h0080,1'b0,1'b0,1'b0,32'h1000_0008,1'b1,4'd8},          // R8 other cs
      '{1'b0,1'b0,32'h0,13'h0100,1'b0,1'b0,1'b0,32'h0000_0008,1'b1,4'd8},          // R8 cs0
      '{1'b1,1'b0,32'hFFFF_FFFF,13'h0000,1'b0,1'b0,1'b0,32'hFD07_DFFF,1'b0,4'd6},  // R6 mask
      '{1'b1,1'b1,32'h0000_1FFF,13'h0000,1'b0,1'b0,1'b1,32'h0000_0000,1'b0,4'd3},  // R3 all
      '{1'b0,1'b0,32'h0,13'h0000,1'b1,1'b0,1'b1,32'h0000_1800,1'b0,4'd10},         // R10
      '{1'b1,1'b1,32'h0000_1800,13'h0800,1'b0,1'b0,1'b1,32'h0000_0800,1'b0,4'd4},  // R4
      '{1'b1,1'b0,32'h1000_0000,13'h0080,1'b0,1'b1,1'b0,32'h1000_0000,1'b1,4'd9},  // R9
      '{1'b0,1'b0,32'h0,13'h0080,1'b0,1'b1,1'b0,32'h0000_0000,1'b1,4'd8}           // R8 cs1
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [12:0] evt_set = '0;
   logic        clk_restart = 1'b0;
   logic        active_cs = 1'b0;
   logic [31:0] ctrl_o;
   logic        run_o;
   logic        irq_o;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nfc_status_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
      .clk_restart(clk_restart), .active_cs(active_cs), .ctrl_o(ctrl_o),
      .run_o(run_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic read_both(input string req, input logic [31:0] ectrl,
                            input logic [31:0] estat, input logic eirq);
      reg_sel = 1'b0; #1;
      chk(req, reg_rdata, ectrl);
      reg_sel = 1'b1; #1;
      chk(req, reg_rdata, estat);
      chk(req, {31'b0, irq_o}, {31'b0, eirq});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      read_both("R1", 32'h0000_0FFF, 32'h0, 1'b0);
      chk("R1", {31'b0, run_o}, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         reg_wr = VEC[i].wr; reg_sel = VEC[i].sel; reg_wdata = VEC[i].wd;
         evt_set = VEC[i].ev; clk_restart = VEC[i].rs; active_cs = VEC[i].cs;
         @(posedge clk); #1;
         reg_wr = 1'b0; evt_set = '0; clk_restart = 1'b0;
         reg_sel = VEC[i].csel; #1;
         chk($sformatf("R%0d vec %0d", VEC[i].req, i), reg_rdata, VEC[i].exp);
         chk($sformatf("R5 irq vec %0d", i), {31'b0, irq_o}, {31'b0, VEC[i].irq});
         if (!VEC[i].csel) begin
            chk("R11 ctrl_o", ctrl_o, VEC[i].exp);
            chk("R11 run_o", {31'b0, run_o}, {31'b0, VEC[i].exp[28]});
         end
      end

      // R1 reset in the middle of activity: load status, then reset
      @(negedge clk) evt_set = 13'h0FFF;
      @(negedge clk) begin evt_set = '0; rst_n = 1'b0; end
      @(negedge clk) rst_n = 1'b1;
      #1;
      read_both("R1 mid", 32'h0000_0FFF, 32'h0, 1'b0);

      // R2 pulse lasts one cycle; bit still set two cycles later
      @(negedge clk) evt_set = 13'h0004;
      @(negedge clk) evt_set = '0;
      @(negedge clk);
      read_both("R2 hold", 32'h0000_0FFF, 32'h0000_0004, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule